// File: doc/BRIEF.md
# ALU Execute Unit with Condition Codes

This block is the execute stage of a simple sequential processor datapath. From the opcode, the function code and the three operand values handed over by decode (two register values and the instruction constant), it picks the two ALU inputs and the ALU function. It then produces the execute result `val_e_o` in the same cycle. Address arithmetic for loads and stores, stack pointer stepping for call, return, push and pop, and pass-through for register moves all use the same adder, with the function forced to addition.

The only storage is a three-bit condition code register. It captures zero, sign and signed overflow of the result on the rising clock edge, and it does so only for ALU-operation instructions. A separate evaluator combines the stored codes with the function code. Its output `cnd_o` tells later stages whether a conditional jump is taken or a conditional move writes back. The evaluator always looks at the codes already held, never at the result still being formed.

Opcode values used throughout: 0 halt, 1 nop, 2 register move (plain or conditional), 3 immediate move, 4 store, 5 load, 6 ALU operation, 7 jump, 8 call, 9 return, 10 push, 11 pop.

Top module: `alu_execute_unit`

## Requirements
- R1: For opcode 6 the low two bits of the function code select the operation, and `val_e_o` = B op A with A = `val_a_i` and B = `val_b_i`. The encodings are 0 add (B+A), 1 subtract (B−A), 2 bitwise and, 3 bitwise xor.
- R2: For every opcode other than 6 the function is addition. Opcode 2 gives `val_e_o` = `val_a_i` (zero plus A), whatever the function code is. Opcode 3 gives `val_e_o` = `val_c_i`. Opcodes 0, 1, 7 and 12 to 15 give `val_e_o` = 0.
- R3: Opcodes 4 and 5 give `val_e_o` = `val_b_i` + `val_c_i` (wrapping).
- R4: Opcodes 8 and 10 give `val_e_o` = `val_b_i` − 8. Opcodes 9 and 11 give `val_e_o` = `val_b_i` + 8.
- R5: `cc_o` is {zero, sign, overflow} with zero in bit 2, sign in bit 1 and overflow in bit 0. After an opcode 6 edge, zero is set exactly when the result was all zeros, and sign equals the result's top bit.
- R6: Overflow is loaded as the signed overflow of add or subtract. It is loaded as 0 for and and xor.
- R7: `cc_o` changes only on a rising clock edge with reset released and opcode 6 present. With any other opcode it holds its value.
- R8: Synchronous active-low reset sets `cc_o` to 3'b100, even while opcode 6 is applied.
- R9: `cnd_o` is derived from the function code and `cc_o`, with lt = sign xor overflow. The codes are 0 always (1), 1 lt or zero, 2 lt, 3 zero, 4 not zero, 5 not lt, 6 not lt and not zero. Codes 7 to 15 give 0.
- R10: `cnd_o` uses the stored codes, so an opcode 6 result affects `cnd_o` only after its clock edge.
- R11: Adding 0x100 and 0x200 with opcode 6 gives 0x300 and leaves `cc_o` at 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the condition codes load on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| icode_i | input | 4 | Opcode of the instruction in execute |
| ifun_i | input | 4 | Function code: ALU operation or condition |
| val_a_i | input | W | First register operand |
| val_b_i | input | W | Second register operand |
| val_c_i | input | W | Instruction constant |
| val_e_o | output | W | Execute result |
| cnd_o | output | 1 | Condition met for jump or conditional move |
| cc_o | output | 3 | Stored condition codes {zero, sign, overflow} |

## Verification
The assertions assume that the opcode, function code and operands are known after reset and change at most once per clock period, away from the rising edge. That way the result sampled at an edge is the one that was loaded into the codes. The bench changes every input only at the falling edge and holds a no-op opcode across reset release. This ensures that no unintended ALU operation slips into the codes. The flag checks after each edge therefore see exactly the instruction that was applied during that cycle.

// File: rtl/exec_pkg.sv
// exec_pkg: shared encodings for the execute unit.
// Assumes a 4-bit opcode and 4-bit function code from decode.
package exec_pkg;

    localparam int OPC_W      = 4;
    localparam int FUN_W      = 4;
    localparam int CC_W       = 3;
    localparam int STACK_STEP = 8;

    typedef enum logic [OPC_W-1:0] {
        OPC_HALT    = 4'h0,
        OPC_NOP     = 4'h1,
        OPC_MOVE_RR = 4'h2,
        OPC_MOVE_IR = 4'h3,
        OPC_STORE   = 4'h4,
        OPC_LOAD    = 4'h5,
        OPC_ALU     = 4'h6,
        OPC_BRANCH  = 4'h7,
        OPC_CALL    = 4'h8,
        OPC_RETURN  = 4'h9,
        OPC_PUSH    = 4'hA,
        OPC_POP     = 4'hB
    } opcode_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'd0,
        FN_SUB = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } alu_fn_e;

    typedef enum logic [FUN_W-1:0] {
        CND_ALWAYS = 4'd0,
        CND_LE     = 4'd1,
        CND_LT     = 4'd2,
        CND_EQ     = 4'd3,
        CND_NE     = 4'd4,
        CND_GE     = 4'd5,
        CND_GT     = 4'd6
    } cond_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/exec_operand_sel.sv
// exec_operand_sel: picks ALU inputs A and B, the ALU function and the
// flag-load enable from the opcode. Assumes only the low two function bits
// matter for ALU operations. Purely combinational.
module exec_operand_sel
    import exec_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [OPC_W-1:0] icode_i,
    input  logic [1:0]       fsel_i,
    input  logic [W-1:0]     val_a_i,
    input  logic [W-1:0]     val_b_i,
    input  logic [W-1:0]     val_c_i,
    output logic [W-1:0]     op_a_o,
    output logic [W-1:0]     op_b_o,
    output alu_fn_e          fn_o,
    output logic             load_cc_o
);

    localparam logic [W-1:0] STEP_POS = W'(STACK_STEP);
    localparam logic [W-1:0] STEP_NEG = W'(0) - STEP_POS;

    // Operand A and B choice per opcode.
    always_comb begin
        op_a_o = '0;
        op_b_o = '0;
        case (icode_i)
            OPC_MOVE_RR: begin op_a_o = val_a_i;  op_b_o = '0;      end
            OPC_MOVE_IR: begin op_a_o = val_c_i;  op_b_o = '0;      end
            OPC_STORE,
            OPC_LOAD:    begin op_a_o = val_c_i;  op_b_o = val_b_i; end
            OPC_ALU:     begin op_a_o = val_a_i;  op_b_o = val_b_i; end
            OPC_CALL,
            OPC_PUSH:    begin op_a_o = STEP_NEG; op_b_o = val_b_i; end
            OPC_RETURN,
            OPC_POP:     begin op_a_o = STEP_POS; op_b_o = val_b_i; end
            default:     begin op_a_o = '0;       op_b_o = '0;      end
        endcase
    end

    // Function select: the function code for ALU ops, add otherwise.
    always_comb begin
        load_cc_o = (icode_i == OPC_ALU);
        fn_o      = load_cc_o ? alu_fn_e'(fsel_i) : FN_ADD;
    end

endmodule

// File: rtl/exec_alu.sv
// exec_alu: four-function ALU returning B op A plus zero, sign and signed
// overflow of the result. Overflow is defined only for add and subtract.
module exec_alu
    import exec_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    input  alu_fn_e      fn_i,
    output logic [W-1:0] result_o,
    output flags_t       flags_o
);

    localparam int MSB = W - 1;

    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic         ovf_add;
    logic         ovf_sub;

    // Arithmetic paths and their signed overflow terms.
    always_comb begin
        sum     = op_b_i + op_a_i;
        diff    = op_b_i - op_a_i;
        ovf_add = (op_a_i[MSB] == op_b_i[MSB]) && (sum[MSB] != op_b_i[MSB]);
        ovf_sub = (op_a_i[MSB] != op_b_i[MSB]) && (diff[MSB] != op_b_i[MSB]);
    end

    // Result multiplexer and flag generation.
    always_comb begin
        case (fn_i)
            FN_ADD:  begin result_o = sum;               flags_o.of = ovf_add; end
            FN_SUB:  begin result_o = diff;              flags_o.of = ovf_sub; end
            FN_AND:  begin result_o = op_b_i & op_a_i;   flags_o.of = 1'b0;    end
            default: begin result_o = op_b_i ^ op_a_i;   flags_o.of = 1'b0;    end
        endcase
        flags_o.zf = (result_o == '0);
        flags_o.sf = result_o[MSB];
    end

endmodule

// File: rtl/exec_cc_reg.sv
// exec_cc_reg: condition code storage, one flop per flag, each with its
// own reset value. Loads only when enabled; synchronous active-low reset.
module exec_cc_reg
    import exec_pkg::*;
#(
    parameter logic [CC_W-1:0] RESET_VAL = FLAGS_RESET
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [CC_W-1:0] d_i,
    output logic [CC_W-1:0] q_o
);

    for (genvar i = 0; i < CC_W; i++) begin : g_flag
        // Hold or load one flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_o[i] <= RESET_VAL[i];
            end else if (load_i) begin
                q_o[i] <= d_i[i];
            end
        end
    end

endmodule

// File: rtl/exec_cond_eval.sv
// exec_cond_eval: turns the stored flags and a condition code into the
// taken / write-back flag. Unlisted codes yield false.
module exec_cond_eval
    import exec_pkg::*;
(
    input  flags_t           flags_i,
    input  logic [FUN_W-1:0] code_i,
    output logic             cnd_o
);

    logic lt;

    // Signed comparison outcome selected by the condition code.
    always_comb begin
        lt = flags_i.sf ^ flags_i.of;
        case (code_i)
            CND_ALWAYS: cnd_o = 1'b1;
            CND_LE:     cnd_o = lt | flags_i.zf;
            CND_LT:     cnd_o = lt;
            CND_EQ:     cnd_o = flags_i.zf;
            CND_NE:     cnd_o = ~flags_i.zf;
            CND_GE:     cnd_o = ~lt;
            CND_GT:     cnd_o = ~lt & ~flags_i.zf;
            default:    cnd_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_execute_unit.sv
// alu_execute_unit: execute stage top. Combines operand selection, the
// ALU, the condition code register and the condition evaluator. Assumes
// inputs are stable for a whole cycle; only the flags are stored.
module alu_execute_unit
    import exec_pkg::*;
#(
    parameter int W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] icode_i,
    input  logic [FUN_W-1:0] ifun_i,
    input  logic [W-1:0]     val_a_i,
    input  logic [W-1:0]     val_b_i,
    input  logic [W-1:0]     val_c_i,
    output logic [W-1:0]     val_e_o,
    output logic             cnd_o,
    output logic [CC_W-1:0]  cc_o
);

    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    alu_fn_e      fn;
    logic         load_cc;
    flags_t       alu_flags;
    flags_t       cc_q;

    exec_operand_sel #(.W(W)) u_sel (
        .icode_i   (icode_i),
        .fsel_i    (ifun_i[1:0]),
        .val_a_i   (val_a_i),
        .val_b_i   (val_b_i),
        .val_c_i   (val_c_i),
        .op_a_o    (op_a),
        .op_b_o    (op_b),
        .fn_o      (fn),
        .load_cc_o (load_cc)
    );

    exec_alu #(.W(W)) u_alu (
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .fn_i     (fn),
        .result_o (val_e_o),
        .flags_o  (alu_flags)
    );

    exec_cc_reg #(.RESET_VAL(FLAGS_RESET)) u_cc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_cc),
        .d_i    (alu_flags),
        .q_o    (cc_q)
    );

    exec_cond_eval u_cond (
        .flags_i (cc_q),
        .code_i  (ifun_i),
        .cnd_o   (cnd_o)
    );

    // Expose the stored flags.
    always_comb cc_o = cc_q;

endmodule

// File: rtl/exec_unit_checker.sv
// exec_unit_checker: protocol and behaviour properties for the execute
// unit, attached by bind. Assumes inputs change once per cycle, away from
// the rising edge.
module exec_unit_checker
    import exec_pkg::*;
#(
    parameter int W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] icode_i,
    input logic [FUN_W-1:0] ifun_i,
    input logic [W-1:0]     val_a_i,
    input logic [W-1:0]     val_b_i,
    input logic [W-1:0]     val_e_o,
    input logic             cnd_o,
    input logic [CC_W-1:0]  cc_o
);

    AST_CC_HOLD_NON_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        (icode_i != OPC_ALU) |=> $stable(cc_o)); // R7

    AST_CC_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (icode_i == OPC_ALU) |=> (cc_o[2] == ($past(val_e_o) == '0))); // R5

    AST_CC_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (icode_i == OPC_ALU) |=> (cc_o[1] == $past(val_e_o[W-1]))); // R5

    AST_NO_OVERFLOW_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
        ((icode_i == OPC_ALU) && (ifun_i inside {4'd2, 4'd3})) |=> !cc_o[0]); // R6

    AST_MOVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (icode_i == OPC_MOVE_RR) |-> (val_e_o == val_a_i)); // R2

    AST_STACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ((icode_i == OPC_CALL) || (icode_i == OPC_PUSH)) |-> (val_e_o == val_b_i - W'(8))); // R4

    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ifun_i == 4'd0) |-> cnd_o); // R9

    AST_EQ_FOLLOWS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ifun_i == 4'd3) |-> (cnd_o == cc_o[2])); // R9

endmodule

bind alu_execute_unit exec_unit_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .icode_i (icode_i),
    .ifun_i  (ifun_i),
    .val_a_i (val_a_i),
    .val_b_i (val_b_i),
    .val_e_o (val_e_o),
    .cnd_o   (cnd_o),
    .cc_o    (cc_o)
);

// File: tb/alu_execute_unit_tb.sv
module alu_execute_unit_tb;

    localparam int W = 64;
    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAXV = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] NEG8 = 64'hFFFF_FFFF_FFFF_FFF8;

    typedef struct packed {
        logic [3:0]  icode;
        logic [3:0]  ifun;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] c;
        logic [63:0] e;
        logic [2:0]  cc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'h6, 4'h0, 64'h200, 64'h100, 64'h0,  64'h300, 3'b000, 8'd11}, // R11 add
        '{4'h6, 4'h1, 64'h5,   64'h5,   64'h0,  64'h0,   3'b100, 8'd1},  // R1 sub zero
        '{4'h6, 4'h1, 64'h6,   64'h5,   64'h0,  ONES,    3'b010, 8'd1},  // R1 sub negative
        '{4'h6, 4'h2, 64'hF0,  64'h3C,  64'h0,  64'h30,  3'b000, 8'd1},  // R1 and
        '{4'h6, 4'h3, 64'hFF,  64'hFF,  64'h0,  64'h0,   3'b100, 8'd5},  // R5 xor zero
        '{4'h6, 4'h0, 64'h1,   MAXV,    64'h0,  MINV,    3'b011, 8'd6},  // R6 add overflow
        '{4'h6, 4'h1, 64'h1,   MINV,    64'h0,  MAXV,    3'b001, 8'd6},  // R6 sub overflow
        '{4'h6, 4'h3, MINV,    64'h0,   64'h0,  MINV,    3'b010, 8'd6},  // R6 xor no overflow
        '{4'h2, 4'h0, 64'h1234,64'h9999,64'h7,  64'h1234,3'b010, 8'd2},  // R2 move, R7 hold
        '{4'h2, 4'h3, 64'hABCD,64'h5,   64'h0,  64'hABCD,3'b010, 8'd2},  // R2 conditional move
        '{4'h3, 4'h0, 64'h1,   64'h2,   64'h55, 64'h55,  3'b010, 8'd2},  // R2 immediate
        '{4'h4, 4'h0, 64'h9,   64'h200, 64'h10, 64'h210, 3'b010, 8'd3},  // R3 store
        '{4'h5, 4'h0, 64'h9,   64'h100, NEG8,   64'hF8,  3'b010, 8'd3},  // R3 load wrap
        '{4'h8, 4'h0, 64'h9,   64'h100, 64'h3,  64'hF8,  3'b010, 8'd4},  // R4 call
        '{4'hA, 4'h0, 64'h9,   64'h40,  64'h3,  64'h38,  3'b010, 8'd4},  // R4 push
        '{4'h9, 4'h0, 64'h9,   64'h100, 64'h3,  64'h108, 3'b010, 8'd4},  // R4 return
        '{4'hB, 4'h0, 64'h9,   64'h0,   64'h3,  64'h8,   3'b010, 8'd4},  // R4 pop
        '{4'h7, 4'h0, 64'h3,   64'h4,   64'h5,  64'h0,   3'b010, 8'd2},  // R2 jump gives zero
        '{4'h1, 4'h0, 64'h9,   64'h9,   64'h9,  64'h0,   3'b010, 8'd7}   // R7 nop
    };

    logic          clk;
    logic          rst_n;
    logic [3:0]    icode;
    logic [3:0]    ifun;
    logic [W-1:0]  va, vb, vc;
    logic [W-1:0]  ve;
    logic          cnd;
    logic [2:0]    cc;

    int checks;
    int failures;
    bit done;

    alu_execute_unit #(.W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .icode_i (icode),
        .ifun_i  (ifun),
        .val_a_i (va),
        .val_b_i (vb),
        .val_c_i (vc),
        .val_e_o (ve),
        .cnd_o   (cnd),
        .cc_o    (cc)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic string tag_of(int r);
        case (r)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [3:0] ic, logic [3:0] fn, logic [63:0] a, logic [63:0] b, logic [63:0] c);
        @(negedge clk);
        icode = ic; ifun = fn; va = a; vb = b; vc = c;
        #1;
    endtask

    task automatic past_edge();
        @(posedge clk);
        #1;
    endtask

    // Expected condition flag from R9: lt = sign xor overflow.
    function automatic logic ref_cnd(logic [2:0] f, int code);
        logic lt;
        lt = f[1] ^ f[0];
        case (code)
            0: return 1'b1;
            1: return lt | f[2];
            2: return lt;
            3: return f[2];
            4: return ~f[2];
            5: return ~lt;
            6: return ~lt & ~f[2];
            default: return 1'b0;
        endcase
    endfunction

    localparam logic [3:0]  SET_FN [5] = '{4'h3, 4'h1, 4'h0, 4'h0, 4'h1};
    localparam logic [63:0] SET_A  [5] = '{64'h7, 64'h6, 64'h1, 64'h1, 64'h1};
    localparam logic [63:0] SET_B  [5] = '{64'h7, 64'h5, 64'h1, MAXV, MINV};
    localparam logic [2:0]  SET_CC [5] = '{3'b100, 3'b010, 3'b000, 3'b011, 3'b001};

    initial begin
        checks = 0; failures = 0; done = 1'b0;
        rst_n = 1'b0;
        icode = 4'h6; ifun = 4'h0; va = 64'h1; vb = 64'h1; vc = 64'h0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "cc under reset with ALU op", {61'b0, cc}, 64'h4);
        @(negedge clk);
        icode = 4'h1;
        rst_n = 1'b1;
        past_edge();
        chk("R7", "cc after nop following reset", {61'b0, cc}, 64'h4);

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].icode, VECS[i].ifun, VECS[i].a, VECS[i].b, VECS[i].c);
            chk(tag_of(int'(VECS[i].req)), $sformatf("val_e vector %0d", i), ve, VECS[i].e);
            past_edge();
            chk(tag_of(int'(VECS[i].req)), $sformatf("cc vector %0d", i), {61'b0, cc}, {61'b0, VECS[i].cc});
        end

        // R10: condition uses stored flags, not the result being formed.
        drive(4'h6, 4'h1, 64'h6, 64'h5, 64'h0);
        past_edge();
        drive(4'h6, 4'h3, 64'h7, 64'h7, 64'h0);
        chk("R10", "cnd before edge", {63'b0, cnd}, 64'h0);
        past_edge();
        chk("R10", "cnd after edge", {63'b0, cnd}, 64'h1);
        chk("R10", "cc after edge", {61'b0, cc}, 64'h4);

        // R9: sweep every condition code over five flag states.
        for (int s = 0; s < 5; s++) begin
            drive(4'h6, SET_FN[s], SET_A[s], SET_B[s], 64'h0);
            past_edge();
            chk("R9", $sformatf("cc setup %0d", s), {61'b0, cc}, {61'b0, SET_CC[s]});
            for (int k = 0; k < 8; k++) begin
                drive(4'h7, 4'(k), 64'h0, 64'h0, 64'h0);
                chk("R9", $sformatf("cnd state %0d code %0d", s, k), {63'b0, cnd}, {63'b0, ref_cnd(SET_CC[s], k)});
            end
        end

        // R8: reset in mid-run restores the zero flag.
        drive(4'h6, 4'h1, 64'h6, 64'h5, 64'h0);
        past_edge();
        @(negedge clk);
        rst_n = 1'b0;
        icode = 4'h1;
        past_edge();
        chk("R8", "cc after mid-run reset", {61'b0, cc}, 64'h4);
        @(negedge clk);
        rst_n = 1'b1;
        past_edge();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule